// File: doc/BRIEF.md
# Multi-Channel Thermal Threshold Monitor

This block watches up to four temperature channels (three in the default build) and turns their converted sample codes into latched events and a single interrupt line. A shared period divider produces a sample strobe every N+1 clock cycles. On each strobe, every enabled channel captures its 12-bit code from the converter input into a result register and compares it against two limits: a hot alarm limit and a shutdown limit.

The code falls as the die heats, so a smaller code means a hotter channel and both limits trip when the code is at or below them. The alarm has a separate release level. Once a channel has alarmed, it raises no further alarm until its code climbs above that release level. The shutdown check has no memory and fires on every sample that is at or below its limit.

All events land in one status register, organised as three groups of channel bits. Software clears them by writing ones. An enable mask selects which status bits drive the registered interrupt output. Software reaches the block through a plain 32-bit register bus with single-cycle writes and reads that return data one cycle later.

Top module: `thermal_monitor`

## Requirements
- R1: After reset, every register reads zero and `irq` is low.
- R2: The control register at 0x40 holds the channel enables in bits 0..NCH-1 and the period value N in bits 31:16. While a channel is enabled, it is sampled once every N+1 clock cycles.
- R3: Each sample of channel i stores the input code in bits 11:0 of the result register at 0x80+4i and sets the data-ready status bit 8+i.
- R4: The shutdown register at 0x60+4i holds a limit in bits 27:16. Every sample whose code is less than or equal to that limit sets status bit 4+i, including repeated samples while the condition holds.
- R5: The alarm register at 0x50+4i holds the hot limit in bits 27:16. A sample whose code is less than or equal to the hot limit sets status bit i and arms the channel, but only if the channel is not already armed.
- R6: An armed channel disarms on a sample whose code is strictly greater than the release level in bits 11:0 of its alarm register. A code equal to the release level keeps the channel armed.
- R7: The status register at 0x48 is write-one-to-clear. A written 1 clears the bit, and a written 0 leaves the bit unchanged.
- R8: The interrupt enable register at 0x44 uses the same bit layout as the status register. `irq` is high one cycle after any status bit is set together with its enable bit.
- R9: A disabled channel takes no samples and raises no events. Its result register and its armed state hold their values.
- R10: Bits with no defined field read as zero, and addresses with no register read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Register write strobe |
| bus_re | input | 1 | Register read strobe; data valid on the next cycle |
| bus_addr | input | AW (8) | Byte address |
| bus_wdata | input | DW (32) | Write data |
| bus_rdata | output | DW (32) | Registered read data |
| samp_code | input | NCH*CW (36) | Converter codes, channel i in bits CW*i+CW-1:CW*i |
| irq | output | 1 | Registered interrupt request |

## Verification
The checker assumes the bus never writes the status register in the same cycle that an event sets a bit; otherwise the write-one-to-clear property would not apply. It also assumes that event pulses come only from a strobe on an enabled channel. The bench follows two rules for every status write. It drops all channel enables first, and it waits for the last strobe's events to settle before touching the status register. The sweep steps each channel's code down through its limits and back up. It holds every code steady for several strobes, so the expected state stays the same however many samples land inside a step.

// File: rtl/thermal_pkg.sv
package thermal_pkg;
  // register offsets
  localparam int OFS_CTRL  = 'h40;
  localparam int OFS_INTEN = 'h44;
  localparam int OFS_STAT  = 'h48;
  localparam int OFS_ALARM = 'h50;
  localparam int OFS_SHUT  = 'h60;
  localparam int OFS_DATA  = 'h80;
  localparam int REG_STRIDE = 4;

  // field positions
  localparam int DIV_LSB = 16;
  localparam int HOT_LSB = 16;
  localparam int REL_LSB = 0;
  localparam int SHT_LSB = 16;

  // status layout: three groups, one bit per channel, group stride 4
  localparam int GRP_SPAN = 4;
  localparam int ALM_POS  = 0;
  localparam int SHD_POS  = 4;
  localparam int RDY_POS  = 8;

  function automatic int stat_width(input int nch);
    return 2 * GRP_SPAN + nch;
  endfunction
endpackage

// File: rtl/tm_divider.sv
module tm_divider #(
  parameter int DIVW = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [DIVW-1:0] div_n,
  output logic            tick
);
  logic [DIVW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (cnt >= div_n) begin
      cnt  <= '0;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt + 1'b1;
      tick <= 1'b0;
    end
  end
endmodule

// File: rtl/tm_channel.sv
module tm_channel #(
  parameter int CW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          tick,
  input  logic [CW-1:0] code_in,
  input  logic [CW-1:0] hot_lim,
  input  logic [CW-1:0] rel_lim,
  input  logic [CW-1:0] sht_lim,
  output logic [CW-1:0] data_q,
  output logic          armed,
  output logic          ev_alm,
  output logic          ev_sht,
  output logic          ev_rdy
);
  logic take;
  assign take = en & tick;

  always_ff @(posedge clk) begin
    if (rst) begin
      data_q <= '0;
      armed  <= 1'b0;
      ev_alm <= 1'b0;
      ev_sht <= 1'b0;
      ev_rdy <= 1'b0;
    end else begin
      ev_alm <= 1'b0;
      ev_sht <= 1'b0;
      ev_rdy <= 1'b0;
      if (take) begin
        data_q <= code_in;
        ev_rdy <= 1'b1;
        ev_sht <= (code_in <= sht_lim);
        if (!armed && (code_in <= hot_lim)) begin
          armed  <= 1'b1;
          ev_alm <= 1'b1;
        end else if (armed && (code_in > rel_lim)) begin
          armed <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/tm_status.sv
module tm_status #(
  parameter int STW = 11
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [STW-1:0] set_ev,
  input  logic [STW-1:0] clr_w1,
  input  logic [STW-1:0] inten,
  output logic [STW-1:0] stat_q,
  output logic           irq
);
  always_ff @(posedge clk) begin
    if (rst) begin
      stat_q <= '0;
      irq    <= 1'b0;
    end else begin
      stat_q <= (stat_q & ~clr_w1) | set_ev;
      irq    <= |(stat_q & inten);
    end
  end
endmodule

// File: rtl/tm_regs.sv
module tm_regs
  import thermal_pkg::*;
#(
  parameter int NCH  = 3,
  parameter int CW   = 12,
  parameter int DIVW = 16,
  parameter int AW   = 8,
  parameter int DW   = 32,
  parameter int STW  = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic              re,
  input  logic [AW-1:0]     addr,
  input  logic [DW-1:0]     wdata,
  input  logic [NCH*CW-1:0] data_flat,
  input  logic [STW-1:0]    stat_q,
  input  logic [STW-1:0]    stat_mask,
  output logic [NCH-1:0]    ch_en,
  output logic [DIVW-1:0]   div_n,
  output logic [STW-1:0]    inten,
  output logic [NCH*CW-1:0] hot_flat,
  output logic [NCH*CW-1:0] rel_flat,
  output logic [NCH*CW-1:0] sht_flat,
  output logic [STW-1:0]    clr_w1,
  output logic [DW-1:0]     rdata
);
  localparam logic [AW-1:0] A_CTRL  = AW'(OFS_CTRL);
  localparam logic [AW-1:0] A_INTEN = AW'(OFS_INTEN);
  localparam logic [AW-1:0] A_STAT  = AW'(OFS_STAT);

  logic [CW-1:0] hot_r [NCH];
  logic [CW-1:0] rel_r [NCH];
  logic [CW-1:0] sht_r [NCH];
  logic [DW-1:0] rd_nxt;
  logic          unused_wbits;

  assign unused_wbits = ^wdata;
  assign clr_w1 = (we && addr == A_STAT) ? (wdata[STW-1:0] & stat_mask) : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      ch_en <= '0;
      div_n <= '0;
      inten <= '0;
    end else if (we) begin
      if (addr == A_CTRL) begin
        ch_en <= wdata[NCH-1:0];
        div_n <= wdata[DIV_LSB +: DIVW];
      end
      if (addr == A_INTEN) inten <= wdata[STW-1:0] & stat_mask;
    end
  end

  for (genvar i = 0; i < NCH; i++) begin : g_lim
    localparam logic [AW-1:0] A_ALM = AW'(OFS_ALARM + REG_STRIDE * i);
    localparam logic [AW-1:0] A_SHT = AW'(OFS_SHUT + REG_STRIDE * i);

    always_ff @(posedge clk) begin
      if (rst) begin
        hot_r[i] <= '0;
        rel_r[i] <= '0;
        sht_r[i] <= '0;
      end else if (we) begin
        if (addr == A_ALM) begin
          hot_r[i] <= wdata[HOT_LSB +: CW];
          rel_r[i] <= wdata[REL_LSB +: CW];
        end
        if (addr == A_SHT) sht_r[i] <= wdata[SHT_LSB +: CW];
      end
    end

    assign hot_flat[i*CW +: CW] = hot_r[i];
    assign rel_flat[i*CW +: CW] = rel_r[i];
    assign sht_flat[i*CW +: CW] = sht_r[i];
  end

  always_comb begin
    rd_nxt = '0;
    if (addr == A_CTRL) begin
      rd_nxt[NCH-1:0]          = ch_en;
      rd_nxt[DIV_LSB +: DIVW]  = div_n;
    end
    if (addr == A_INTEN) rd_nxt[STW-1:0] = inten;
    if (addr == A_STAT)  rd_nxt[STW-1:0] = stat_q;
    for (int i = 0; i < NCH; i++) begin
      if (addr == AW'(OFS_ALARM + REG_STRIDE * i)) begin
        rd_nxt[HOT_LSB +: CW] = hot_r[i];
        rd_nxt[REL_LSB +: CW] = rel_r[i];
      end
      if (addr == AW'(OFS_SHUT + REG_STRIDE * i))
        rd_nxt[SHT_LSB +: CW] = sht_r[i];
      if (addr == AW'(OFS_DATA + REG_STRIDE * i))
        rd_nxt[CW-1:0] = data_flat[i*CW +: CW];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)     rdata <= '0;
    else if (re) rdata <= rd_nxt;
  end
endmodule

// File: rtl/thermal_monitor.sv
module thermal_monitor
  import thermal_pkg::*;
#(
  parameter int NCH  = 3,
  parameter int CW   = 12,
  parameter int DIVW = 16,
  parameter int AW   = 8,
  parameter int DW   = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_we,
  input  logic              bus_re,
  input  logic [AW-1:0]     bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  input  logic [NCH*CW-1:0] samp_code,
  output logic              irq
);
  localparam int STW = stat_width(NCH);

  logic [NCH-1:0]    ch_en;
  logic [DIVW-1:0]   div_n;
  logic [STW-1:0]    inten;
  logic [STW-1:0]    stat_q;
  logic [STW-1:0]    clr_w1;
  logic [STW-1:0]    set_ev;
  logic [STW-1:0]    stat_mask;
  logic [NCH*CW-1:0] hot_flat, rel_flat, sht_flat, data_flat;
  logic [NCH-1:0]    ev_alm, ev_sht, ev_rdy, armed;
  logic              tick;

  always_comb begin
    stat_mask = '0;
    set_ev    = '0;
    for (int i = 0; i < NCH; i++) begin
      stat_mask[ALM_POS + i] = 1'b1;
      stat_mask[SHD_POS + i] = 1'b1;
      stat_mask[RDY_POS + i] = 1'b1;
      set_ev[ALM_POS + i]    = ev_alm[i];
      set_ev[SHD_POS + i]    = ev_sht[i];
      set_ev[RDY_POS + i]    = ev_rdy[i];
    end
  end

  tm_regs #(
    .NCH(NCH), .CW(CW), .DIVW(DIVW), .AW(AW), .DW(DW), .STW(STW)
  ) u_regs (
    .clk(clk), .rst(rst), .we(bus_we), .re(bus_re), .addr(bus_addr),
    .wdata(bus_wdata), .data_flat(data_flat), .stat_q(stat_q),
    .stat_mask(stat_mask), .ch_en(ch_en), .div_n(div_n), .inten(inten),
    .hot_flat(hot_flat), .rel_flat(rel_flat), .sht_flat(sht_flat),
    .clr_w1(clr_w1), .rdata(bus_rdata)
  );

  tm_divider #(.DIVW(DIVW)) u_div (
    .clk(clk), .rst(rst), .div_n(div_n), .tick(tick)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    tm_channel #(.CW(CW)) u_ch (
      .clk(clk), .rst(rst), .en(ch_en[i]), .tick(tick),
      .code_in(samp_code[i*CW +: CW]),
      .hot_lim(hot_flat[i*CW +: CW]),
      .rel_lim(rel_flat[i*CW +: CW]),
      .sht_lim(sht_flat[i*CW +: CW]),
      .data_q(data_flat[i*CW +: CW]),
      .armed(armed[i]),
      .ev_alm(ev_alm[i]), .ev_sht(ev_sht[i]), .ev_rdy(ev_rdy[i])
    );
  end

  tm_status #(.STW(STW)) u_stat (
    .clk(clk), .rst(rst), .set_ev(set_ev), .clr_w1(clr_w1),
    .inten(inten), .stat_q(stat_q), .irq(irq)
  );
endmodule

// File: rtl/tm_checker.sv
module tm_checker
  import thermal_pkg::*;
#(
  parameter int NCH  = 3,
  parameter int CW   = 12,
  parameter int DIVW = 16,
  parameter int AW   = 8,
  parameter int DW   = 32,
  parameter int STW  = 11
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_we,
  input logic [AW-1:0]     bus_addr,
  input logic [DW-1:0]     bus_wdata,
  input logic [STW-1:0]    stat_q,
  input logic [STW-1:0]    set_ev,
  input logic [STW-1:0]    inten,
  input logic              irq,
  input logic              tick,
  input logic [DIVW-1:0]   div_n,
  input logic [NCH-1:0]    ch_en,
  input logic [NCH-1:0]    armed,
  input logic [NCH-1:0]    ev_alm,
  input logic [NCH-1:0]    ev_sht,
  input logic [NCH*CW-1:0] data_flat
);
  localparam logic [AW-1:0] A_STAT = AW'(OFS_STAT);

  // R7: a written 1 clears the bit when no event sets it in that cycle
  a_r7_w1c: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_addr == A_STAT && set_ev == '0)
      |=> ((stat_q & $past(bus_wdata[STW-1:0])) == '0));

  // R7: without a status write, no bit ever falls
  a_r7_sticky: assert property (@(posedge clk) disable iff (rst)
    !(bus_we && bus_addr == A_STAT)
      |=> ((stat_q & $past(stat_q)) == $past(stat_q)));

  // R8: the interrupt rises only from an enabled pending bit
  a_r8_irq_src: assert property (@(posedge clk) disable iff (rst)
    irq |-> ($past(stat_q & inten) != '0));

  // R2: a nonzero period leaves at least one idle cycle after a strobe
  a_r2_tick_gap: assert property (@(posedge clk) disable iff (rst)
    (tick && div_n != '0) |=> !tick);

  for (genvar i = 0; i < NCH; i++) begin : g_chk
    // R5: an alarm event fires only from the disarmed state
    a_r5_once: assert property (@(posedge clk) disable iff (rst)
      ev_alm[i] |-> !$past(armed[i]));

    // R9: events come only from a strobe on an enabled channel
    a_r9_event_src: assert property (@(posedge clk) disable iff (rst)
      (ev_alm[i] || ev_sht[i]) |-> $past(ch_en[i] && tick));

    // R9: result register holds without a strobe on an enabled channel
    a_r9_data_hold: assert property (@(posedge clk) disable iff (rst)
      !(ch_en[i] && tick) |=> $stable(data_flat[i*CW +: CW]));
  end
endmodule

bind thermal_monitor tm_checker #(
  .NCH(NCH), .CW(CW), .DIVW(DIVW), .AW(AW), .DW(DW), .STW(STW)
) u_chk (
  .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .stat_q(stat_q), .set_ev(set_ev), .inten(inten),
  .irq(irq), .tick(tick), .div_n(div_n), .ch_en(ch_en), .armed(armed),
  .ev_alm(ev_alm), .ev_sht(ev_sht), .data_flat(data_flat)
);

// File: tb/sim_thermal_monitor.sv
module sim_thermal_monitor;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 3;
  localparam int CW  = 12;
  localparam int PER = 3;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              we = 1'b0, re = 1'b0;
  logic [7:0]        addr = '0;
  logic [31:0]       wdata = '0;
  logic [31:0]       rdata;
  logic [NCH*CW-1:0] samp_man = '0;
  logic [NCH*CW-1:0] samp;
  logic              irq;
  logic [CW-1:0]     cyc = '0;
  bit                cnt_mode = 1'b0;

  int n_vec = 0;
  int n_bad = 0;

  bit          act  [NCH];
  logic [11:0] last [NCH];
  logic [11:0] hot  [NCH];
  logic [11:0] rel  [NCH];
  logic [11:0] sht  [NCH];
  logic [31:0] ien;

  assign samp = cnt_mode ? {samp_man[NCH*CW-1:CW], cyc} : samp_man;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(negedge clk) cyc <= cyc + 1'b1;

  thermal_monitor u0 (
    .clk(clk), .rst(rst), .bus_we(we), .bus_re(re), .bus_addr(addr),
    .bus_wdata(wdata), .bus_rdata(rdata), .samp_code(samp), .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act_v, input logic [31:0] exp_v);
    n_vec++;
    if (act_v !== exp_v) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act_v, exp_v);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    re = 1'b1; addr = a;
    @(negedge clk);
    re = 1'b0;
    @(negedge clk);
    d = rdata;
  endtask

  task automatic step(input int ch, input logic [11:0] code);
    logic [31:0] v, ex;
    bit a_ev, s_ev;
    samp_man[ch*CW +: CW] = code;
    wr(8'h40, (32'(PER) << 16) | (32'd1 << ch));
    repeat (12) @(negedge clk);
    wr(8'h40, 32'(PER) << 16);
    repeat (3) @(negedge clk);
    s_ev = (code <= sht[ch]);
    a_ev = 1'b0;
    if (!act[ch] && code <= hot[ch]) begin
      act[ch] = 1'b1; a_ev = 1'b1;
    end else if (act[ch] && code > rel[ch]) begin
      act[ch] = 1'b0;
    end
    last[ch] = code;
    ex = (32'(a_ev) << ch) | (32'(s_ev) << (4 + ch)) | (32'd1 << (8 + ch));
    rd(8'h48, v);
    chk("R3 R4 R5 R6 status after sample", v, ex);
    chk("R8 irq with pending status", 32'(irq), 32'((ex & ien) != 0));
    for (int j = 0; j < NCH; j++) begin
      rd(8'h80 + 8'(4 * j), v);
      chk(j == ch ? "R3 result register" : "R9 disabled channel holds result",
          v, 32'(last[j]));
    end
    wr(8'h48, 32'h0);
    rd(8'h48, v);
    chk("R7 zero write keeps status", v, ex);
    wr(8'h48, 32'hFFFF_FFFF);
    rd(8'h48, v);
    chk("R7 one write clears status", v, 32'h0);
    chk("R8 irq low after clear", 32'(irq), 32'h0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_bad++;
    $display("FAIL all: watchdog expired actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] v, d1, d2;
    logic [11:0] df;
    for (int i = 0; i < NCH; i++) begin
      act[i] = 1'b0; last[i] = '0;
    end
    samp_man = {12'h111, 12'h222, 12'h333};
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    chk("R1 irq after reset", 32'(irq), 32'h0);
    for (int a = 'h40; a < 'h90; a += 4) begin
      rd(8'(a), v);
      chk("R1 register reads zero after reset", v, 32'h0);
    end
    repeat (10) @(negedge clk);
    rd(8'h80, v);
    chk("R9 disabled after reset takes no sample", v, 32'h0);

    // R10 undefined bits and holes
    wr(8'h50, 32'hFFFF_FFFF);
    rd(8'h50, v); chk("R10 alarm register field bits", v, 32'h0FFF_0FFF);
    wr(8'h60, 32'hFFFF_FFFF);
    rd(8'h60, v); chk("R10 shutdown register field bits", v, 32'h0FFF_0000);
    wr(8'h44, 32'hFFFF_FFFF);
    rd(8'h44, v); chk("R10 interrupt enable field bits", v, 32'h0000_0777);
    wr(8'h40, 32'hFFFF_FFF8);
    rd(8'h40, v); chk("R2 R10 control register fields", v, 32'hFFFF_0000);
    rd(8'h3C, v); chk("R10 unmapped address", v, 32'h0);
    rd(8'h8C, v); chk("R10 unmapped address past results", v, 32'h0);
    wr(8'h40, 32'h0);
    wr(8'h44, 32'h0);

    // sweeps per channel
    for (int ch = 0; ch < NCH; ch++) begin
      hot[ch] = 12'h400 - 12'(ch * 'h40);
      rel[ch] = hot[ch] + 12'h080;
      sht[ch] = hot[ch] - 12'h200;
      wr(8'h50 + 8'(4 * ch), {4'h0, hot[ch], 4'h0, rel[ch]});
      wr(8'h60 + 8'(4 * ch), {4'h0, sht[ch], 16'h0});
      ien = (ch == 2) ? 32'h070 : 32'h007;
      wr(8'h44, ien);
      for (int k = 0; k < 32; k++) step(ch, 12'h800 - 12'(k * 'h40));
      for (int k = 0; k < 32; k++) step(ch, 12'h041 + 12'(k * 'h40));
      // R6 release level boundary
      step(ch, hot[ch]);
      step(ch, rel[ch]);
      step(ch, hot[ch]);
      step(ch, rel[ch] + 12'h001);
      step(ch, hot[ch]);
      step(ch, rel[ch] + 12'h001);
    end

    // R2 sampling period N+1 with N=9
    cnt_mode = 1'b1;
    wr(8'h40, (32'd9 << 16) | 32'd1);
    repeat (40) @(negedge clk);
    wr(8'h40, 32'd9 << 16);
    repeat (3) @(negedge clk);
    rd(8'h80, d1);
    wr(8'h40, (32'd9 << 16) | 32'd1);
    repeat (23) @(negedge clk);
    wr(8'h40, 32'd9 << 16);
    repeat (3) @(negedge clk);
    rd(8'h80, d2);
    df = d2[11:0] - d1[11:0];
    chk("R2 capture spacing multiple of N+1", 32'((df % 12'd10) == 0 && df != 0), 32'h1);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule